// File: doc/BRIEF.md
# Peripheral Trap Interrupt Status Block

This block records which peripheral address traps have fired and turns any recorded trap into a system-management interrupt request. An external address decoder sends one single-cycle hit pulse per device class whenever an access falls inside that device's watched range. Software programs an enable register to choose which of those hits are recorded.

A hit on an enabled trap sets a sticky bit in a status register. That bit holds until software clears it by writing 0 to its position. Writing 1 to a status bit has no effect. If a hardware set and a software clear of the same bit land in the same cycle, the set wins, so no trap event is lost. The request output is a registered OR of all status bits.

Both registers are eight bits wide and are reached through a simple synchronous write and combinational read bus. Address range decoding and the global interrupt enable lie outside this block.

Top module: `trap_smi_block`

## Requirements
- R1: After reset the enable register (offset 0) and the status register (offset 1) both read 00h, and `smi_req` is 0.
- R2: While enable bit i is 1, a pulse on `trap_hit[i]` sets status bit i at that clock edge. The status bit positions are: 0 device 1, 1 device 2, 2 device 3, 3 serial port, 4 audio, 5 IDE. A set bit stays set over later cycles with no further hits.
- R3: A pulse on `trap_hit[i]` while enable bit i is 0 leaves status bit i unchanged.
- R4: A write to offset 1 clears every status bit whose written data bit is 0 and leaves every bit written as 1 unchanged. Status bits change only through hits and through such writes.
- R5: If status bit i is set by an enabled hit in the same cycle that software writes 0 to it, the bit reads 1 afterwards.
- R6: Bits 7:6 of both registers always read 0, whatever value was written to them. Offsets 2 and 3 read 00h and ignore writes.
- R7: `smi_req` is registered. It goes to 1 one clock after any status bit is 1, and it goes to 0 one clock after all status bits are 0.
- R8: Clearing an enable bit leaves an already set status bit, and the request, unchanged.
- R9: Bits 5:0 written to offset 0 read back unchanged and take effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 2 | Register offset: 0 enable, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| trap_hit | input | 6 | Per-trap hit pulses from the address decoder |
| smi_req | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that `trap_hit` is a set of single-cycle pulses sampled at clock edges and that a register write holds its address and data steady for the cycle its strobe is high. They also assume status changes come only from the named set and clear vectors. The bench drives every input on the falling edge and keeps hit pulses and write strobes exactly one cycle wide. It only overlaps a hit with a status write in the test that deliberately targets the set-versus-clear collision.

// File: rtl/trap_smi_pkg.sv
package trap_smi_pkg;

  parameter int unsigned REG_W = 8;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_NONE   = 2'd2
  } reg_sel_e;

  // Low n bits set, the rest clear.
  function automatic logic [REG_W-1:0] low_mask(input int unsigned n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < REG_W; k++) begin
      if (k < n) m[k] = 1'b1;
    end
    return m;
  endfunction

  // Sticky update: clear requests drop bits, set requests win over them.
  function automatic logic sticky_next(input logic cur, input logic set_req,
                                       input logic clr_req);
    return (cur & ~clr_req) | set_req;
  endfunction

  // A written 0 is a clear request, a written 1 leaves the bit as it was.
  function automatic logic zero_clears(input logic wr_hit, input logic data_bit);
    return wr_hit & ~data_bit;
  endfunction

endpackage

// File: rtl/trap_reg_decode.sv
module trap_reg_decode
  import trap_smi_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned EN_OFF   = 0,
  parameter int unsigned STAT_OFF = 1
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              en_we,
  output logic              stat_we
);

  always_comb begin
    if (addr == ADDR_W'(EN_OFF))        sel = SEL_ENABLE;
    else if (addr == ADDR_W'(STAT_OFF)) sel = SEL_STATUS;
    else                                sel = SEL_NONE;
  end

  assign en_we   = wr_en && (sel == SEL_ENABLE);
  assign stat_we = wr_en && (sel == SEL_STATUS);

endmodule

// File: rtl/trap_enable_reg.sv
module trap_enable_reg #(
  parameter int unsigned NUM_TRAPS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [NUM_TRAPS-1:0] wdata,
  output logic [NUM_TRAPS-1:0] en_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  en_q <= '0;
    else if (we) en_q <= wdata;
  end

endmodule

// File: rtl/trap_status_reg.sv
module trap_status_reg
  import trap_smi_pkg::*;
#(
  parameter int unsigned NUM_TRAPS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [NUM_TRAPS-1:0] wdata,
  input  logic [NUM_TRAPS-1:0] hit,
  input  logic [NUM_TRAPS-1:0] en,
  output logic [NUM_TRAPS-1:0] set_vec,
  output logic [NUM_TRAPS-1:0] clr_vec,
  output logic [NUM_TRAPS-1:0] status_q
);

  for (genvar i = 0; i < NUM_TRAPS; i++) begin : g_bit
    assign set_vec[i] = hit[i] & en[i];
    assign clr_vec[i] = zero_clears(we, wdata[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= sticky_next(status_q[i], set_vec[i], clr_vec[i]);
    end
  end

endmodule

// File: rtl/trap_irq_gen.sv
module trap_irq_gen #(
  parameter int unsigned NUM_TRAPS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TRAPS-1:0] status,
  output logic                 req
);

  logic any_pending;
  assign any_pending = |status;

  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= any_pending;
  end

endmodule

// File: rtl/trap_smi_block.sv
module trap_smi_block
  import trap_smi_pkg::*;
#(
  parameter int unsigned NUM_TRAPS = 6,
  parameter int unsigned ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NUM_TRAPS-1:0] trap_hit,
  output logic                 smi_req
);

  localparam logic [REG_W-1:0] LIVE_MASK = low_mask(NUM_TRAPS);

  reg_sel_e             sel;
  logic                 en_we;
  logic                 stat_we;
  logic [NUM_TRAPS-1:0] en_q;
  logic [NUM_TRAPS-1:0] status_q;
  logic [NUM_TRAPS-1:0] set_vec;
  logic [NUM_TRAPS-1:0] clr_vec;

  trap_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .sel     (sel),
    .en_we   (en_we),
    .stat_we (stat_we)
  );

  trap_enable_reg #(.NUM_TRAPS(NUM_TRAPS)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (en_we),
    .wdata (reg_wdata[NUM_TRAPS-1:0]),
    .en_q  (en_q)
  );

  trap_status_reg #(.NUM_TRAPS(NUM_TRAPS)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (stat_we),
    .wdata    (reg_wdata[NUM_TRAPS-1:0]),
    .hit      (trap_hit),
    .en       (en_q),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .status_q (status_q)
  );

  trap_irq_gen #(.NUM_TRAPS(NUM_TRAPS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status_q),
    .req    (smi_req)
  );

  // Reserved write data bits are not stored anywhere.
  if (NUM_TRAPS < REG_W) begin : g_rsv
    logic unused_rsv_wdata;
    assign unused_rsv_wdata = ^reg_wdata[REG_W-1:NUM_TRAPS];
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_ENABLE: reg_rdata[NUM_TRAPS-1:0] = en_q;
      SEL_STATUS: reg_rdata[NUM_TRAPS-1:0] = status_q;
      default:    reg_rdata = '0;
    endcase
    reg_rdata = reg_rdata & LIVE_MASK;
  end

endmodule

// File: rtl/trap_smi_chk.sv
module trap_smi_chk #(
  parameter int unsigned NUM_TRAPS = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_TRAPS-1:0] set_vec,
  input logic [NUM_TRAPS-1:0] clr_vec,
  input logic [NUM_TRAPS-1:0] status_q,
  input logic                 smi_req
);

  // R2
  enabled_hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R3
  rise_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));

  // R4
  fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status_q & $past(status_q) & ~$past(clr_vec)) == '0));

  // R5
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=>
      ((status_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  // R7
  req_follows_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != '0) |=> smi_req);

  // R7
  req_drops_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |=> !smi_req);

endmodule

bind trap_smi_block trap_smi_chk #(.NUM_TRAPS(NUM_TRAPS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .set_vec  (set_vec),
  .clr_vec  (clr_vec),
  .status_q (status_q),
  .smi_req  (smi_req)
);

// File: tb/tb_trap_smi_block.sv
module tb_trap_smi_block;

  localparam int unsigned NT = 6;
  localparam logic [1:0] A_EN = 2'd0;
  localparam logic [1:0] A_ST = 2'd1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [NT-1:0] trap_hit = '0;
  logic          smi_req;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  trap_smi_block dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .trap_hit  (trap_hit),
    .smi_req   (smi_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [NT-1:0] h);
    @(negedge clk);
    trap_hit = h;
    @(negedge clk);
    trap_hit = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_EN, v); check("R1 enable", v, 8'h00);
    rd(A_ST, v); check("R1 status", v, 8'h00);
    check("R1 smi_req", {7'd0, smi_req}, 8'h00);
  endtask

  task automatic t_enable_rw();
    logic [7:0] v;
    wr(A_EN, 8'hA5); rd(A_EN, v); check("R9 enable readback", v, 8'h25);
    wr(A_EN, 8'hFF); rd(A_EN, v); check("R6 enable reserved", v, 8'h3F);
    wr(A_ST, 8'hFF); rd(A_ST, v); check("R6 status reserved", v, 8'h00);
    wr(2'd2, 8'hFF); rd(2'd2, v); check("R6 offset 2", v, 8'h00);
    rd(A_EN, v); check("R6 offset 2 write ignored", v, 8'h3F);
    rd(2'd3, v); check("R6 offset 3", v, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    wr(A_EN, 8'h00);
    pulse(6'h3F);
    rd(A_ST, v); check("R3 all disabled", v, 8'h00);
    wr(A_EN, 8'h15);
    pulse(6'h3F);
    rd(A_ST, v); check("R3 partial enable", v, 8'h15);
    wr(A_ST, 8'h00);
  endtask

  task automatic t_walk();
    logic [7:0] v;
    wr(A_EN, 8'h3F);
    for (int i = 0; i < NT; i++) begin
      pulse(NT'(1) << i);
      repeat (3) @(negedge clk);
      rd(A_ST, v); check($sformatf("R2 bit %0d", i), v, 8'(1) << i);
      wr(A_ST, ~(8'(1) << i));
      rd(A_ST, v); check($sformatf("R4 clear bit %0d", i), v, 8'h00);
    end
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wr(A_EN, 8'h3F);
    pulse(6'h3F);
    wr(A_ST, 8'hFF); rd(A_ST, v); check("R4 write ones", v, 8'h3F);
    wr(A_ST, 8'hF5); rd(A_ST, v); check("R4 clear 1 and 3", v, 8'h35);
    wr(A_ST, 8'h00); rd(A_ST, v); check("R4 clear all", v, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    wr(A_EN, 8'h3F);
    pulse(6'h01);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = A_ST; reg_wdata = 8'h00; trap_hit = 6'h04;
    @(negedge clk);
    reg_wr_en = 1'b0; trap_hit = '0;
    rd(A_ST, v); check("R5 set wins on fresh bit", v, 8'h04);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = A_ST; reg_wdata = 8'h00; trap_hit = 6'h04;
    @(negedge clk);
    reg_wr_en = 1'b0; trap_hit = '0;
    rd(A_ST, v); check("R5 set wins on held bit", v, 8'h04);
    wr(A_ST, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(A_EN, 8'h3F);
    @(negedge clk);
    check("R7 idle", {7'd0, smi_req}, 8'h00);
    pulse(6'h20);
    check("R7 one clock lag", {7'd0, smi_req}, 8'h00);
    @(negedge clk);
    check("R7 raised", {7'd0, smi_req}, 8'h01);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = A_ST; reg_wdata = 8'h00;
    @(negedge clk);
    reg_wr_en = 1'b0;
    check("R7 drop lag", {7'd0, smi_req}, 8'h01);
    @(negedge clk);
    check("R7 dropped", {7'd0, smi_req}, 8'h00);
    rd(A_ST, v); check("R7 status empty", v, 8'h00);
  endtask

  task automatic t_en_off();
    logic [7:0] v;
    wr(A_EN, 8'h3F);
    pulse(6'h10);
    wr(A_EN, 8'h00);
    repeat (2) @(negedge clk);
    rd(A_ST, v); check("R8 status kept", v, 8'h10);
    check("R8 request kept", {7'd0, smi_req}, 8'h01);
    wr(A_ST, 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_rw();
    t_disabled();
    t_walk();
    t_clear();
    t_collide();
    t_irq();
    t_en_off();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule